// File: doc/BRIEF.md
# TLB Set-Index and Way-Replacement Controller

This block is the control half of a four-way set-associative translation buffer with 32 sets. It computes the set index from a virtual page number and the current address-space identifier. The index is taken either straight from the page number or XOR-folded with the identifier. It keeps one valid bit for each way of each set. It also holds a small control word: translation enable, single-address-space mode, index hashing mode, a write-only flush strobe and a 2-bit replacement counter. The counter names the way that the next refill writes.

The surrounding buffer pulses `miss_evt` when a lookup misses. It pulses `exc_evt` with the offending way when another translation fault occurs. It raises `refill_we` to install an entry at the current set. All of these events apply to the set selected by `look_vpn` and `look_asid` in the same cycle. Tag and data storage, comparison, protection and exception handling stay outside. All pins are plain control pins with no stream handshake: every event is taken in the cycle it is presented, and nothing can stall the block.

Top module: `tlb_way_ctrl`

## Requirements
- R1: With `hash_idx`=0, `set_idx` equals `look_vpn[4:0]` in the same cycle (`look_vpn` bit 0 is address bit 12).
- R2: With `hash_idx`=1, `set_idx` equals `look_vpn[4:0]` XOR `look_asid[4:0]` in the same cycle.
- R3: A miss at a set whose four ways are all valid makes `victim_way` equal to its previous value plus 1, wrapping from 3 to 0, from the next cycle on.
- R4: A miss at a set with any invalid way makes `victim_way` equal to the lowest-numbered invalid way of that set, from the next cycle on.
- R5: An exception event without a miss loads `victim_way` with `exc_way`. When a miss and an exception arrive in the same cycle, the miss rule applies.
- R6: A refill sets the valid bit of way `victim_way` (value before the edge) at `set_idx`. `set_valid` shows the change from the next cycle.
- R7: Writing the control word with bit 0 set clears every valid bit of every set at the next edge. It wins over a refill in the same cycle, and bit 0 always reads as 0.
- R8: The control word holds `xlate_en` at bit 1, `hash_idx` at bit 2, `single_vs` at bit 3 and the replacement counter at bits 5:4. It reads back with all other bits 0, and the control fields change only on a write.
- R9: Software can write the counter through bits 5:4. A miss or exception in the same cycle takes precedence over that write.
- R10: After reset, the control word reads 0, `victim_way` is 0 and every valid bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read value |
| look_vpn | input | 20 | Virtual page number of the current access |
| look_asid | input | 8 | Current address-space identifier |
| miss_evt | input | 1 | Lookup missed at the current set |
| exc_evt | input | 1 | Non-miss translation fault |
| exc_way | input | 2 | Way that caused the fault |
| refill_we | input | 1 | Install an entry at the current set |
| set_idx | output | 5 | Set index of the current access |
| set_valid | output | 4 | Valid bits of the current set |
| victim_way | output | 2 | Replacement counter |
| xlate_en | output | 1 | Translation enable |
| single_vs | output | 1 | Single-address-space mode |

## Verification
A corrupted valid bit shows on `set_valid` as soon as that set is addressed. It shows again one cycle after the next miss at that set, because `victim_way` then moves to the wrong way. A wrong counter appears on `victim_way` one cycle after the event that loaded it. Every later refill then lands in the wrong way, so the error spreads into `set_valid`. A wrong index mode is visible combinationally on `set_idx`. A flush that leaves a bit behind appears when any set is swept.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
  localparam int CFG_W      = 32;
  localparam int BIT_FLUSH  = 0;
  localparam int BIT_XLATE  = 1;
  localparam int BIT_HASH   = 2;
  localparam int BIT_SINGLE = 3;
  localparam int BIT_RC_LO  = 4;

  typedef struct packed {
    logic single_vs;
    logic hash_idx;
    logic xlate_en;
  } ctrl_t;
endpackage

// File: rtl/tlbw_index.sv
module tlbw_index #(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int SET_W  = 5
) (
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ASID_W-1:0] asid,
  input  logic              hash_idx,
  output logic [SET_W-1:0]  idx
);
  logic [SET_W-1:0] mix;

  generate
    if (ASID_W >= SET_W) begin : g_wide_asid
      assign mix = asid[SET_W-1:0];
    end else begin : g_narrow_asid
      assign mix = {{(SET_W-ASID_W){1'b0}}, asid};
    end
  endgenerate

  always_comb begin
    idx = vpn[SET_W-1:0];
    if (hash_idx) idx = vpn[SET_W-1:0] ^ mix;
  end
endmodule

// File: rtl/tlbw_valid_array.sv
module tlbw_valid_array #(
  parameter int NWAYS = 4,
  parameter int SET_W = 5,
  localparam int WAY_W = $clog2(NWAYS),
  localparam int NSETS = 1 << SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [SET_W-1:0]  rd_set,
  output logic [NWAYS-1:0]  rd_bits
);
  logic [NWAYS-1:0] vbits [NSETS];
  logic             any_valid;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int s = 0; s < NSETS; s++) vbits[s] <= '0;
    end else if (wr_en) begin
      vbits[wr_set][wr_way] <= 1'b1;
    end
  end

  assign rd_bits = vbits[rd_set];

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < NSETS; s++) any_valid = any_valid | (|vbits[s]);
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !any_valid); // R7
  AST_REFILL_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> vbits[$past(wr_set)][$past(wr_way)]); // R6
endmodule

// File: rtl/tlbw_victim.sv
module tlbw_victim #(
  parameter int NWAYS = 4,
  localparam int WAY_W = $clog2(NWAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss,
  input  logic             exc,
  input  logic [WAY_W-1:0] exc_way,
  input  logic [NWAYS-1:0] set_vld,
  input  logic             sw_we,
  input  logic [WAY_W-1:0] sw_rc,
  output logic [WAY_W-1:0] rc
);
  logic             free_hit;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    free_hit = 1'b0;
    free_way = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (!set_vld[w]) begin
        free_hit = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rc <= '0;
    end else if (miss) begin
      rc <= free_hit ? free_way : rc + 1'b1;
    end else if (exc) begin
      rc <= exc_way;
    end else if (sw_we) begin
      rc <= sw_rc;
    end
  end

  AST_FULL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && (&set_vld)) |=> rc == WAY_W'($past(rc) + 1'b1)); // R3
  AST_WAY0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !set_vld[0]) |=> rc == '0); // R4
  AST_WAY1_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && set_vld[0] && !set_vld[1]) |=> rc == WAY_W'(1)); // R4
  AST_EXC_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc && !miss) |=> rc == $past(exc_way)); // R5
  AST_SW_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !miss && !exc) |=> rc == $past(sw_rc)); // R9
endmodule

// File: rtl/tlb_way_ctrl.sv
module tlb_way_ctrl
  import tlbw_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int SET_W  = 5,
  parameter int NWAYS  = 4,
  localparam int WAY_W = $clog2(NWAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [VPN_W-1:0]  look_vpn,
  input  logic [ASID_W-1:0] look_asid,
  input  logic              miss_evt,
  input  logic              exc_evt,
  input  logic [WAY_W-1:0]  exc_way,
  input  logic              refill_we,
  output logic [SET_W-1:0]  set_idx,
  output logic [NWAYS-1:0]  set_valid,
  output logic [WAY_W-1:0]  victim_way,
  output logic              xlate_en,
  output logic              single_vs
);
  ctrl_t ctrl_q;
  logic  flush_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (cfg_we) begin
      ctrl_q.xlate_en  <= cfg_wdata[BIT_XLATE];
      ctrl_q.hash_idx  <= cfg_wdata[BIT_HASH];
      ctrl_q.single_vs <= cfg_wdata[BIT_SINGLE];
    end
  end

  assign flush_req = cfg_we & cfg_wdata[BIT_FLUSH];

  tlbw_index #(.VPN_W(VPN_W), .ASID_W(ASID_W), .SET_W(SET_W)) u_index (
    .vpn      (look_vpn),
    .asid     (look_asid),
    .hash_idx (ctrl_q.hash_idx),
    .idx      (set_idx)
  );

  tlbw_valid_array #(.NWAYS(NWAYS), .SET_W(SET_W)) u_valid (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush_req),
    .wr_en   (refill_we),
    .wr_set  (set_idx),
    .wr_way  (victim_way),
    .rd_set  (set_idx),
    .rd_bits (set_valid)
  );

  tlbw_victim #(.NWAYS(NWAYS)) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .miss    (miss_evt),
    .exc     (exc_evt),
    .exc_way (exc_way),
    .set_vld (set_valid),
    .sw_we   (cfg_we),
    .sw_rc   (cfg_wdata[BIT_RC_LO +: WAY_W]),
    .rc      (victim_way)
  );

  always_comb begin
    cfg_rdata                      = '0;
    cfg_rdata[BIT_XLATE]           = ctrl_q.xlate_en;
    cfg_rdata[BIT_HASH]            = ctrl_q.hash_idx;
    cfg_rdata[BIT_SINGLE]          = ctrl_q.single_vs;
    cfg_rdata[BIT_RC_LO +: WAY_W]  = victim_way;
  end

  assign xlate_en  = ctrl_q.xlate_en;
  assign single_vs = ctrl_q.single_vs;

  AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(xlate_en) && $stable(single_vs) && $stable(cfg_rdata[BIT_HASH]))); // R8
  AST_RC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !miss_evt && !exc_evt) |=> $stable(victim_way)); // R9
endmodule

// File: tb/test_tlb_way_ctrl.sv
`timescale 1ns/1ps
module test_tlb_way_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [19:0] look_vpn = '0;
  logic [7:0]  look_asid = '0;
  logic        miss_evt = 1'b0, exc_evt = 1'b0, refill_we = 1'b0;
  logic [1:0]  exc_way = '0;
  logic [4:0]  set_idx;
  logic [3:0]  set_valid;
  logic [1:0]  victim_way;
  logic        xlate_en, single_vs;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [3:0] vm [32];
  logic [1:0] rc_m;
  logic       hash_m;
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  tlb_way_ctrl i_tlb_way_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .look_vpn(look_vpn), .look_asid(look_asid),
    .miss_evt(miss_evt), .exc_evt(exc_evt), .exc_way(exc_way),
    .refill_we(refill_we), .set_idx(set_idx), .set_valid(set_valid),
    .victim_way(victim_way), .xlate_en(xlate_en), .single_vs(single_vs)
  );

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cfg_write(input logic [31:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    step();
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  function automatic logic [4:0] exp_idx(input logic [19:0] v, input logic [7:0] a, input logic h);
    return h ? (v[4:0] ^ a[4:0]) : v[4:0];
  endfunction

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected < 150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 rdata", cfg_rdata, 32'h0);
    chk("R10 victim", {30'b0, victim_way}, 32'h0);
    for (int s = 0; s < 32; s++) begin
      look_vpn = 20'(s); #1;
      chk("R10 valid", {28'b0, set_valid}, 32'h0);
    end

    // R1 / R2: index sweep in both modes
    for (int h = 0; h < 2; h++) begin
      cfg_write(h ? 32'h4 : 32'h0);
      for (int v = 0; v < 32; v++) begin
        for (int a = 0; a < 32; a += (h ? 1 : 7)) begin
          look_vpn  = {15'(v * 977), 5'(v)};
          look_asid = {3'(a), 5'(a)};
          #1;
          chk(h ? "R2 hashed index" : "R1 plain index", {27'b0, set_idx},
              {27'b0, exp_idx(look_vpn, look_asid, 1'(h))});
        end
      end
    end

    // R8: field positions and reserved bits
    cfg_write(32'hFFFF_FFFE);
    chk("R8 readback all", cfg_rdata, 32'h0000_003E);
    chk("R8 xlate_en", {31'b0, xlate_en}, 32'h1);
    chk("R8 single_vs", {31'b0, single_vs}, 32'h1);
    cfg_write(32'h0000_0008);
    chk("R8 readback sv", cfg_rdata, 32'h0000_0008);
    chk("R8 xlate off", {31'b0, xlate_en}, 32'h0);
    cfg_write(32'h0);
    rc_m = 2'd0;
    for (int s = 0; s < 32; s++) vm[s] = 4'h0;

    // Model-driven sequences; R3..R7, R9
    for (int ph = 0; ph < 2; ph++) begin
      hash_m = 1'(ph);
      cfg_write({26'b0, 2'b00, 1'b0, hash_m, 2'b00});
      rc_m = 2'd0;
      for (int n = 0; n < 3000; n++) begin
        logic [4:0] s;
        logic [1:0] rc_n;
        logic       fh;
        logic [1:0] fw;
        logic       fl;
        rng = nxt(rng);
        look_vpn  = {rng[31:17], 2'b00, rng[2:0]};
        look_asid = {5'b0, rng[5:3]};
        miss_evt  = rng[6] & rng[7];
        exc_evt   = rng[8] & rng[9] & rng[10];
        exc_way   = rng[12:11];
        refill_we = rng[13];
        cfg_we    = (rng[17:14] == 4'h0);
        fl        = rng[18] & rng[19];
        cfg_wdata = {26'b0, rng[21:20], rng[22], hash_m, rng[23], fl};
        #1;
        s = exp_idx(look_vpn, look_asid, hash_m);
        chk("R1/R2 index in sequence", {27'b0, set_idx}, {27'b0, s});
        fh = 1'b0; fw = 2'd0;
        for (int w = 3; w >= 0; w--) if (!vm[s][w]) begin fh = 1'b1; fw = 2'(w); end
        rc_n = rc_m;
        if (miss_evt) rc_n = fh ? fw : rc_m + 2'd1;
        else if (exc_evt) rc_n = exc_way;
        else if (cfg_we) rc_n = cfg_wdata[5:4];
        if (cfg_we && fl) begin
          for (int k = 0; k < 32; k++) vm[k] = 4'h0;
        end else if (refill_we) begin
          vm[s][rc_m] = 1'b1;
        end
        rc_m = rc_n;
        step();
        miss_evt = 0; exc_evt = 0; refill_we = 0; cfg_we = 0; cfg_wdata = '0;
        #1;
        chk(miss_evt ? "R3/R4 victim" : "R3/R4/R5/R9 victim", {30'b0, victim_way}, {30'b0, rc_m});
        chk("R6/R7 set_valid", {28'b0, set_valid}, {28'b0, vm[exp_idx(look_vpn, look_asid, hash_m)]});
        chk("R7 flush bit reads 0", {31'b0, cfg_rdata[0]}, 32'h0);
      end
    end

    // R7: explicit flush with simultaneous refill, then sweep every set
    refill_we = 1'b1;
    cfg_write({26'b0, rc_m, 1'b0, hash_m, 2'b01});
    refill_we = 1'b0;
    cfg_write({26'b0, rc_m, 1'b0, 1'b0, 2'b00});
    for (int s = 0; s < 32; s++) begin
      look_vpn = 20'(s); #1;
      chk("R7 flush sweep", {28'b0, set_valid}, 32'h0);
    end

    // R3: wrap from 3 to 0 on a full set
    look_vpn = 20'd9; look_asid = '0;
    for (int w = 0; w < 4; w++) begin
      cfg_write({26'b0, 2'(w), 4'b0000});
      refill_we = 1'b1; step(); refill_we = 1'b0;
    end
    chk("R6 full set", {28'b0, set_valid}, 32'hF);
    cfg_write({26'b0, 2'd3, 4'b0000});
    miss_evt = 1'b1; step(); miss_evt = 1'b0;
    chk("R3 wrap 3->0", {30'b0, victim_way}, 32'h0);
    // R5: miss wins over exception
    look_vpn = 20'd10;
    miss_evt = 1'b1; exc_evt = 1'b1; exc_way = 2'd2; step();
    miss_evt = 1'b0; exc_evt = 1'b0;
    chk("R5 miss beats exception", {30'b0, victim_way}, 32'h0);

    finish_run();
  end
endmodule